// File: doc/BRIEF.md
# Three-Table Microcode Sequencer

This block is the control engine of a small microprogrammed processor. A 6-bit state register addresses a main lookup table. The table returns a 26-bit control word, which drives the datapath's bus drivers, register loads, memory write, register-select and ALU function lines. The same word also carries the state's own successor.

Two smaller tables give the other ways to reach a next state. The first is indexed by the 4-bit instruction opcode and gives the first state of each instruction at the end of fetch. The second is indexed by the one-bit comparison result and is used by the conditional branches. Two flags inside the control word pick which of the three sources loads the state register. An enable input lets the machine be single-stepped. The contents of all three tables are parameters, so a microprogram is supplied at instantiation.

Top module: `ucode_seq`

## Requirements
- R1: While reset is active, and after it is released until the first enabled edge, the state is 0 and `ctrl_word` equals main-table entry 0.
- R2: `ctrl_word` always equals the main-table entry at the current state, with no register between them. Its bits 5:0 are the successor field, bit 23 is the opcode-dispatch flag and bit 24 is the compare-dispatch flag.
- R3: On an enabled rising edge with both dispatch flags low, the state loads bits 5:0 of the current control word.
- R4: On an enabled edge with only bit 23 set, the state loads the opcode-table entry selected by `opcode`.
- R5: On an enabled edge with only bit 24 set, the state loads condition-table entry 1 when `cmp_true` is high and entry 0 when it is low.
- R6: If bits 23 and 24 are both set, the state falls back to the successor field in bits 5:0. A strict-mode check reports this combination as an error.
- R7: While `step_en` is low, the state and `ctrl_word` do not change, whatever `opcode` and `cmp_true` do.
- R8: A state whose successor field names itself stays put under any `opcode` or `cmp_true`, and its control word keeps every load and write bit (bits 18:11) at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| step_en | input | 1 | Advances the state register when high |
| opcode | input | 4 | Instruction opcode that indexes the dispatch table |
| cmp_true | input | 1 | Comparison result that indexes the condition table |
| ctrl_word | output | 26 | Control word of the current state |

## Verification
The bench loads its own microprogram, in which every entry differs and is computed arithmetically. It then walks the machine with pseudo-random opcodes, comparison bits and step gaps, and predicts each control word from its own state model. The corner cases it targets are these:
- a state that sets both dispatch flags, where a design that decoded the unused mux code would jump to a garbage or zero state;
- the condition table, where a design that swapped the false and true entries would take every branch backwards;
- disabled edges, where a design that ignored the enable would race ahead;
- the halt loop, where a design that let the opcode table override it would leave the halt state.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

  localparam int unsigned UCS_STATE_W = 6;
  localparam int unsigned UCS_OPC_W   = 4;
  localparam int unsigned UCS_CW_W    = 26;

  // control word field positions that the sequencer itself decodes
  localparam int unsigned CW_NEXT_LSB = 0;
  localparam int unsigned CW_OPDISP   = 23;
  localparam int unsigned CW_CMPDISP  = 24;

  localparam int unsigned UCS_MAIN_BITS = UCS_CW_W << UCS_STATE_W;
  localparam int unsigned UCS_SEQ_BITS  = UCS_STATE_W << UCS_OPC_W;
  localparam int unsigned UCS_COND_BITS = UCS_STATE_W * 2;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_OPC  = 2'b01,
    SRC_CMP  = 2'b10,
    SRC_BAD  = 2'b11
  } ucs_src_e;

  // minimal default program: two fetch states, dispatch, everything else parks in 63
  function automatic logic [UCS_MAIN_BITS-1:0] ucs_default_main();
    logic [UCS_MAIN_BITS-1:0] t;
    t = '0;
    for (int s = 0; s < (1 << UCS_STATE_W); s++) begin
      logic [UCS_CW_W-1:0] w;
      w = '0;
      case (s)
        0:       w = UCS_CW_W'(1) | (UCS_CW_W'(1) << 9)  | (UCS_CW_W'(1) << 13);
        1:       w = UCS_CW_W'(2) | (UCS_CW_W'(1) << 7)  | (UCS_CW_W'(1) << 12);
        2:       w = UCS_CW_W'(63) | (UCS_CW_W'(1) << CW_OPDISP);
        default: w = UCS_CW_W'(63);
      endcase
      t[s*UCS_CW_W +: UCS_CW_W] = w;
    end
    return t;
  endfunction

endpackage

// File: rtl/ucs_table.sv
module ucs_table #(
  parameter int unsigned                      AW   = 4,
  parameter int unsigned                      DW   = 6,
  parameter logic [DW*(2**AW)-1:0]            INIT = '0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] entries [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign entries[g] = INIT[g*DW +: DW];
  end

  always_comb data = entries[addr];
endmodule

// File: rtl/ucs_next_sel.sv
module ucs_next_sel
  import ucs_pkg::*;
#(
  parameter int unsigned SW = UCS_STATE_W
) (
  input  logic          op_disp,
  input  logic          cmp_disp,
  input  logic [SW-1:0] main_nxt,
  input  logic [SW-1:0] opc_nxt,
  input  logic [SW-1:0] cmp_nxt,
  output logic [SW-1:0] nxt
);
  ucs_src_e src;

  always_comb begin
    src = ucs_src_e'({cmp_disp, op_disp});
    unique case (src)
      SRC_OPC: nxt = opc_nxt;
      SRC_CMP: nxt = cmp_nxt;
      default: nxt = main_nxt;   // SRC_MAIN and the illegal SRC_BAD
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucs_pkg::*;
#(
  parameter int unsigned                   STATE_W    = UCS_STATE_W,
  parameter int unsigned                   OPC_W      = UCS_OPC_W,
  parameter int unsigned                   CW_W       = UCS_CW_W,
  parameter logic [CW_W*(2**STATE_W)-1:0]  MAIN_TBL   = ucs_default_main(),
  parameter logic [STATE_W*(2**OPC_W)-1:0] OPC_TBL    = {(2**OPC_W){6'd63}},
  parameter logic [STATE_W*2-1:0]          CMP_TBL    = '0,
  parameter bit                            STRICT_SEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [OPC_W-1:0] opcode,
  input  logic             cmp_true,
  output logic [CW_W-1:0]  ctrl_word
);
  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic [STATE_W-1:0] state_q, state_d;
  logic [STATE_W-1:0] opc_nxt, cmp_nxt, sel_nxt;
  logic               strict_chk;

  assign strict_chk = STRICT_SEL;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ucs_table #(.AW(STATE_W), .DW(CW_W), .INIT(MAIN_TBL)) i_main (
    .addr (state_q),
    .data (ctrl_word)
  );

  ucs_table #(.AW(OPC_W), .DW(STATE_W), .INIT(OPC_TBL)) i_opc (
    .addr (opcode),
    .data (opc_nxt)
  );

  ucs_table #(.AW(1), .DW(STATE_W), .INIT(CMP_TBL)) i_cmp (
    .addr (cmp_true),
    .data (cmp_nxt)
  );

  ucs_next_sel #(.SW(STATE_W)) i_sel (
    .op_disp  (ctrl_word[CW_OPDISP]),
    .cmp_disp (ctrl_word[CW_CMPDISP]),
    .main_nxt (ctrl_word[CW_NEXT_LSB +: STATE_W]),
    .opc_nxt  (opc_nxt),
    .cmp_nxt  (cmp_nxt),
    .nxt      (sel_nxt)
  );

  always_comb begin
    state_d = state_q;
    if (step_en) state_d = sel_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= '0;
    else            state_q <= state_d;
  end
endmodule

// File: rtl/ucs_chk.sv
module ucs_chk #(
  parameter int unsigned SW = 6,
  parameter int unsigned CW = 26
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          step_en,
  input logic          strict_chk,
  input logic [CW-1:0] ctrl_word,
  input logic [SW-1:0] state_q,
  input logic [SW-1:0] opc_nxt,
  input logic [SW-1:0] cmp_nxt
);
  logic op_d, cmp_d;
  assign op_d  = ctrl_word[23];
  assign cmp_d = ctrl_word[24];

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(strict_chk && op_d && cmp_d)); // R6

  AST_CLASH_FALLBACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_en && op_d && cmp_d) |=> state_q == $past(ctrl_word[SW-1:0])); // R6

  AST_MAIN_PATH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_en && !op_d && !cmp_d) |=> state_q == $past(ctrl_word[SW-1:0])); // R3

  AST_OPC_PATH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_en && op_d && !cmp_d) |=> state_q == $past(opc_nxt)); // R4

  AST_CMP_PATH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_en && cmp_d && !op_d) |=> state_q == $past(cmp_nxt)); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !step_en |=> $stable(state_q)); // R7
endmodule

bind ucode_seq ucs_chk #(.SW(STATE_W), .CW(CW_W)) i_ucs_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .step_en    (step_en),
  .strict_chk (strict_chk),
  .ctrl_word  (ctrl_word),
  .state_q    (state_q),
  .opc_nxt    (opc_nxt),
  .cmp_nxt    (cmp_nxt)
);

// File: tb/test_ucode_seq.sv
`timescale 1ns/1ps
module test_ucode_seq;
  localparam int SW = 6;
  localparam int OW = 4;
  localparam int CW = 26;

  function automatic logic [CW-1:0] entry(input int s);
    logic [CW-1:0] w;
    logic [5:0]    sv;
    sv = 6'(s);
    w = '0;
    w[5:0]   = (s == 63) ? 6'd63 : 6'(s + 1);
    w[10:6]  = sv[4:0];
    w[18:11] = (s == 63) ? 8'd0 : 8'(s * 3 + 1);
    w[22:19] = sv[3:0];
    w[23]    = (s == 3 || s == 20 || s == 40 || s == 55);
    w[24]    = (s == 10 || s == 30 || s == 50 || s == 55);
    w[25]    = sv[5];
    return w;
  endfunction

  function automatic logic [5:0] opc_entry(input int op);
    return (op == 9) ? 6'd52 : 6'((op * 5 + 7) % 50);
  endfunction

  function automatic logic [CW*64-1:0] mk_main();
    logic [CW*64-1:0] t;
    for (int s = 0; s < 64; s++) t[s*CW +: CW] = entry(s);
    return t;
  endfunction

  function automatic logic [SW*16-1:0] mk_opc();
    logic [SW*16-1:0] t;
    for (int o = 0; o < 16; o++) t[o*SW +: SW] = opc_entry(o);
    return t;
  endfunction

  // entry 0 = condition false, entry 1 = condition true
  localparam logic [5:0] CMP_F = 6'd44;
  localparam logic [5:0] CMP_T = 6'd17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en;
  logic [OW-1:0] opcode;
  logic          cmp_true;
  logic [CW-1:0] ctrl_word;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    mstate = 0;
  string tag    = "R1";
  bit    done   = 1'b0;
  int unsigned rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  ucode_seq #(
    .MAIN_TBL   (mk_main()),
    .OPC_TBL    (mk_opc()),
    .CMP_TBL    ({CMP_T, CMP_F}),
    .STRICT_SEL (1'b0)
  ) i_ucode_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .opcode    (opcode),
    .cmp_true  (cmp_true),
    .ctrl_word (ctrl_word)
  );

  task automatic check(input string req, input logic [CW-1:0] exp);
    n_chk++;
    if (ctrl_word !== exp) begin
      n_fail++;
      $display("FAIL %s state=%0d actual=%h expected=%h", req, mstate, ctrl_word, exp);
    end
  endtask

  // one clock: check at the falling edge, then drive and predict the next state
  task automatic cyc(input logic en, input logic [3:0] op, input logic cmp);
    logic [CW-1:0] w;
    logic [5:0]    nx;
    string         nt;
    @(negedge clk);
    check({"R2/", tag}, entry(mstate));
    step_en  = en;
    opcode   = op;
    cmp_true = cmp;
    w = entry(mstate);
    if (w[23] && !w[24]) begin
      nx = opc_entry(int'(op)); nt = "R4";
    end else if (w[24] && !w[23]) begin
      nx = cmp ? CMP_T : CMP_F; nt = "R5";
    end else begin
      nx = w[5:0];
      nt = (w[23] && w[24]) ? "R6" : ((mstate == 63) ? "R8" : "R3");
    end
    if (!en) nt = "R7";
    @(posedge clk);
    if (en) mstate = int'(nx);
    tag = nt;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step_en = 1'b0; opcode = '0; cmp_true = 1'b0;
    mstate = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", entry(0));
    rst_n = 1'b1;
    tag = "R1";
    repeat (4) cyc(1'b0, 4'd9, 1'b1);   // idle across the synchroniser release
  endtask

  initial begin
    do_reset();
    // random walk: opcode 9 is kept for the halt run
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      op = rng[7:4];
      if (op == 4'd9) op = 4'd8;
      cyc(rng[2:0] != 3'd0, op, rng[9]);
    end
    // directed path: dispatch to 52, through the clash state 55, into halt 63
    do_reset();
    for (int i = 0; i < 80; i++) cyc(1'b1, 4'd9, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 4'(i), 1'(i));
    @(negedge clk);
    n_chk++;
    if (mstate != 63 || ctrl_word[18:11] !== 8'd0) begin
      n_fail++;
      $display("FAIL R8 state=%0d loads=%h expected state=63 loads=00", mstate, ctrl_word[18:11]);
    end
    check("R8 halt word", entry(63));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule